// File: doc/BRIEF.md
# Spike-Triggered Program/Erase Pulse Sequencer

This block generates the control strobes for a threshold modulator built around a resistive memory cell. After reset it holds every path off for a programmable warm-up time, then settles into a low-stress rest mode. Each neuron spike starts a sequence: a short program (SET) phase of programmable length, then an erase (RESET) phase. The erase phase has no fixed length. It runs until the next spike or until a programmable settle time runs out, whichever comes first.

A spike during the erase phase cuts that phase short and starts a fresh program phase. When no spike comes before the settle time runs out, the block drops into the rest mode. In that mode only the rest path is enabled and a reduced supply is selected. All timing counts millisecond ticks (`ms_tick`), a one-cycle strobe. Every path enable is also driven as a separate complement output for the analog switches. The current phase is also available as a code.

Top module: `thr_pulse_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `phase_o` is 0 (warm-up), all enables and `low_supply_sel` are 0, and all complement outputs are 1.
- R2: The warm-up phase (`phase_o`=0) ends in the cycle after the tick that completes `init_ticks` ticks, counting from reset. A value of 0 acts as 1. The next phase is rest (`phase_o`=1). Spikes during warm-up are ignored and no path is enabled.
- R3: A spike sampled in rest moves the block to program (`phase_o`=2) at the next clock edge.
- R4: Program ends in the cycle after the tick that completes `set_ticks` ticks, counting from entry to program. A value of 0 acts as 1. Spikes during program, including one on the final tick, are ignored and are not stored.
- R5: Program is followed by exactly one cycle with all paths off (`phase_o`=3), then erase (`phase_o`=4). A spike in that dead cycle is ignored.
- R6: A spike sampled in erase moves the block to one dead cycle (`phase_o`=5), then to program. A spike in that dead cycle is ignored.
- R7: If no spike comes, erase ends in rest in the cycle after the tick that completes `settle_ticks` ticks, counting from entry to erase. A value of 0 acts as 1. A spike on that same final tick wins, and R6 applies.
- R8: `set_en` is 1 exactly in program, `reset_en` exactly in erase, and `idle_en` and `low_supply_sel` exactly in rest.
- R9: Each complement output is always the inverse of its enable.
- R10: `set_en` and `reset_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| spike | input | 1 | Neuron output spike, one sample per cycle |
| init_ticks | input | CNT_W | Warm-up length in ticks |
| set_ticks | input | CNT_W | Program phase length in ticks |
| settle_ticks | input | CNT_W | Erase time before rest, in ticks |
| set_en | output | 1 | Program path enable |
| set_en_n | output | 1 | Complement of set_en |
| reset_en | output | 1 | Erase path enable |
| reset_en_n | output | 1 | Complement of reset_en |
| idle_en | output | 1 | Rest path enable |
| idle_en_n | output | 1 | Complement of idle_en |
| low_supply_sel | output | 1 | Selects the reduced supply in rest |
| phase_o | output | 3 | Phase code: 0 warm-up, 1 rest, 2 program, 3 program-to-erase gap, 4 erase, 5 erase-to-program gap |

## Verification
The phase code is on a port, so a wrong phase register or a mis-counted tick shows as a `phase_o` mismatch in the first cycle after the edge where the transition happens or should have happened. A wrong enable decode, or a complement flop that drifts, shows on the path pins in that same cycle. A spike that is stored instead of dropped, or a missing dead cycle, shows at the latest one clock later as an early program phase or a direct program-to-erase step. The bench runs a cycle model of the phases in lockstep with the design and compares every output in every cycle, so no fault can hide for longer than one phase.

// File: rtl/thr_seq_pkg.sv
package thr_seq_pkg;

  typedef enum logic [2:0] {
    PH_INIT   = 3'd0,
    PH_IDLE   = 3'd1,
    PH_SET    = 3'd2,
    PH_GAP_SR = 3'd3,
    PH_RESET  = 3'd4,
    PH_GAP_RS = 3'd5
  } phase_t;

  localparam int NPATH = 3;  // path order: 0 program, 1 erase, 2 rest

  function automatic logic [NPATH-1:0] path_decode(input phase_t ph);
    logic [NPATH-1:0] v;
    v    = '0;
    v[0] = (ph == PH_SET);
    v[1] = (ph == PH_RESET);
    v[2] = (ph == PH_IDLE);
    return v;
  endfunction

endpackage

// File: rtl/thr_phase_timer.sv
module thr_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             done
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // a zero length behaves as one tick
  assign done    = tick && (cnt_inc >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !restart) |=> (cnt_q == CNT_MAX)); // R7

endmodule

// File: rtl/thr_drive_stage.sv
module thr_drive_stage
  import thr_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_t           nxt_phase,
  output logic [NPATH-1:0] en_q,
  output logic [NPATH-1:0] en_n_q,
  output logic             low_q
);

  logic [NPATH-1:0] en_d;
  assign en_d = path_decode(nxt_phase);

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[g]   <= 1'b0;
        en_n_q[g] <= 1'b1;
      end else begin
        en_q[g]   <= en_d[g];
        en_n_q[g] <= ~en_d[g];
      end
    end

    AST_PATH_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
      en_q[g] != en_n_q[g]); // R9
  end

  always_ff @(posedge clk) begin
    if (rst) low_q <= 1'b0;
    else     low_q <= (nxt_phase == PH_IDLE);
  end

endmodule

// File: rtl/thr_pulse_seq.sv
module thr_pulse_seq
  import thr_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ms_tick,
  input  logic             spike,
  input  logic [CNT_W-1:0] init_ticks,
  input  logic [CNT_W-1:0] set_ticks,
  input  logic [CNT_W-1:0] settle_ticks,
  output logic             set_en,
  output logic             set_en_n,
  output logic             reset_en,
  output logic             reset_en_n,
  output logic             idle_en,
  output logic             idle_en_n,
  output logic             low_supply_sel,
  output logic [2:0]       phase_o
);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cur_len;
  logic             ph_done;
  logic [NPATH-1:0] en_q, en_n_q;
  logic             low_q;

  always_comb begin
    unique case (phase_q)
      PH_INIT:  cur_len = init_ticks;
      PH_RESET: cur_len = settle_ticks;
      default:  cur_len = set_ticks;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_INIT:   if (ph_done) phase_d = PH_IDLE;
      PH_IDLE:   if (spike)   phase_d = PH_SET;
      PH_SET:    if (ph_done) phase_d = PH_GAP_SR;
      PH_GAP_SR: phase_d = PH_RESET;
      PH_RESET: begin
        if (spike)        phase_d = PH_GAP_RS;
        else if (ph_done) phase_d = PH_IDLE;
      end
      PH_GAP_RS: phase_d = PH_SET;
      default:   phase_d = PH_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_INIT;
    else     phase_q <= phase_d;
  end

  thr_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (ms_tick),
    .restart (phase_d != phase_q),
    .len     (cur_len),
    .done    (ph_done)
  );

  thr_drive_stage drive_i (
    .clk       (clk),
    .rst       (rst),
    .nxt_phase (rst ? PH_INIT : phase_d),
    .en_q      (en_q),
    .en_n_q    (en_n_q),
    .low_q     (low_q)
  );

  assign set_en         = en_q[0];
  assign set_en_n       = en_n_q[0];
  assign reset_en       = en_q[1];
  assign reset_en_n     = en_n_q[1];
  assign idle_en        = en_q[2];
  assign idle_en_n      = en_n_q[2];
  assign low_supply_sel = low_q;
  assign phase_o        = phase_q;

  AST_SET_RESET_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(set_en && reset_en)); // R10

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INIT) |-> (!set_en && !reset_en && !idle_en)); // R2

  AST_ONE_DEAD_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_GAP_SR) |=> (phase_q == PH_RESET)); // R5

  AST_SET_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(set_en) |-> ($past(phase_q) == PH_IDLE || $past(phase_q) == PH_GAP_RS)); // R6

  AST_ERASE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_en) |-> ($past(phase_q) == PH_GAP_SR)); // R5

endmodule

// File: tb/thr_pulse_seq_tb_top.sv
module thr_pulse_seq_tb_top;
  import thr_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WDOG_LIMIT = 150000;

  logic             clk = 1'b0;
  logic             rst;
  logic             ms_tick, spike;
  logic [CNT_W-1:0] init_ticks, set_ticks, settle_ticks;
  logic             set_en, set_en_n, reset_en, reset_en_n;
  logic             idle_en, idle_en_n, low_supply_sel;
  logic [2:0]       phase_o;

  int n_cmp  = 0;
  int n_fail = 0;
  int cyc    = 0;

  phase_t           m_ph;
  logic [CNT_W-1:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_pulse_seq #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .spike(spike),
    .init_ticks(init_ticks), .set_ticks(set_ticks), .settle_ticks(settle_ticks),
    .set_en(set_en), .set_en_n(set_en_n), .reset_en(reset_en), .reset_en_n(reset_en_n),
    .idle_en(idle_en), .idle_en_n(idle_en_n), .low_supply_sel(low_supply_sel),
    .phase_o(phase_o)
  );

  function automatic string req_of(input phase_t p);
    case (p)
      PH_INIT:   return "R2";
      PH_IDLE:   return "R3/R8";
      PH_SET:    return "R4";
      PH_GAP_SR: return "R5";
      PH_RESET:  return "R7";
      default:   return "R6";
    endcase
  endfunction

  function automatic logic tick_ends(input logic [CNT_W-1:0] cnt, input logic [CNT_W-1:0] len, input logic tk);
    int unsigned need;
    need = (len == 0) ? 1 : int'(len);
    return tk && ((int'(cnt) + 1) >= need);
  endfunction

  function automatic phase_t model_next(input phase_t p, input logic [CNT_W-1:0] cnt,
                                        input logic tk, input logic sp);
    case (p)
      PH_INIT:   return tick_ends(cnt, init_ticks, tk) ? PH_IDLE : PH_INIT;
      PH_IDLE:   return sp ? PH_SET : PH_IDLE;
      PH_SET:    return tick_ends(cnt, set_ticks, tk) ? PH_GAP_SR : PH_SET;
      PH_GAP_SR: return PH_RESET;
      PH_RESET:  return sp ? PH_GAP_RS : (tick_ends(cnt, settle_ticks, tk) ? PH_IDLE : PH_RESET);
      default:   return PH_SET;
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic check_outputs();
    string r;
    r = req_of(m_ph);
    cmp(r, "phase_o", phase_o, 3'(m_ph));
    cmp("R8", "set_en", {2'b0, set_en}, {2'b0, m_ph == PH_SET});
    cmp("R8", "reset_en", {2'b0, reset_en}, {2'b0, m_ph == PH_RESET});
    cmp("R8", "idle_en", {2'b0, idle_en}, {2'b0, m_ph == PH_IDLE});
    cmp("R8", "low_supply_sel", {2'b0, low_supply_sel}, {2'b0, m_ph == PH_IDLE});
    cmp("R9", "complements", {set_en_n, reset_en_n, idle_en_n}, ~{set_en, reset_en, idle_en});
    cmp("R10", "set/reset overlap", {2'b0, set_en & reset_en}, 3'd0);
  endtask

  task automatic step(input logic tk, input logic sp);
    phase_t nx;
    @(negedge clk);
    ms_tick = tk;
    spike   = sp;
    nx = model_next(m_ph, m_cnt, tk, sp);
    if (nx != m_ph) m_cnt = '0;
    else if (tk && m_cnt != '1) m_cnt = m_cnt + 1'b1;
    m_ph = nx;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_outputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ms_tick = 1'b0; spike = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: reset state
    cmp("R1", "phase_o in reset", phase_o, 3'd0);
    cmp("R1", "enables in reset", {set_en, reset_en, idle_en}, 3'd0);
    cmp("R1", "complements in reset", {set_en_n, reset_en_n, idle_en_n}, 3'b111);
    cmp("R1", "low supply in reset", {2'b0, low_supply_sel}, 3'd0);
    @(negedge clk);
    rst = 1'b0;
    m_ph = PH_INIT; m_cnt = '0;
  endtask

  task automatic run_random(input int ncyc, input int tick_pct, input int spike_pct);
    for (int i = 0; i < ncyc; i++) begin
      step(($urandom % 100) < tick_pct, ($urandom % 100) < spike_pct);
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED);
    rst = 1'b1; ms_tick = 1'b0; spike = 1'b0;
    init_ticks = 16'd3; set_ticks = 16'd2; settle_ticks = 16'd6;
    do_reset();

    // R2: spikes during warm-up ignored, tick each cycle
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    cmp("R2", "warm-up done to rest", phase_o, 3'(PH_IDLE));
    // R3: spike in rest
    step(1'b0, 1'b1);
    cmp("R3", "rest to program", phase_o, 3'(PH_SET));
    // R4: spike on final program tick not stored
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    cmp("R4", "program ended", phase_o, 3'(PH_GAP_SR));
    step(1'b0, 1'b1);
    cmp("R5", "erase after one gap", phase_o, 3'(PH_RESET));
    // R7: spike coinciding with final settle tick wins
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    cmp("R7", "spike beats settle timeout", phase_o, 3'(PH_GAP_RS));
    step(1'b0, 1'b0);
    cmp("R6", "program after erase gap", phase_o, 3'(PH_SET));
    run_random(3000, 50, 10);

    // zero lengths behave as one tick
    init_ticks = 16'd0; set_ticks = 16'd0; settle_ticks = 16'd0;
    do_reset();
    run_random(2000, 40, 15);

    init_ticks = 16'd5; set_ticks = 16'd4; settle_ticks = 16'd20;
    do_reset();
    run_random(6000, 60, 3);

    init_ticks = 16'd1; set_ticks = 16'd1; settle_ticks = 16'd3;
    do_reset();
    run_random(3000, 90, 30);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_LIMIT) begin
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d expected below %0d cycles", cyc, WDOG_LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
      end
    end
  end

endmodule